// File: doc/BRIEF.md
# Converter Settling and Calibration Sequencer

This block is the control state machine of an oversampling converter's digital back end. It runs on the master clock and counts master clock cycles to decide when the decimation filter output can be trusted. After a chip reset, or after a synchronous restart request, it holds its valid flag low for one full filter window plus one output word. It then raises the flag and pulses a data-ready strobe once per output word.

A calibration request moves the block through a chain of measurement phases, each one filter window long, with a short gap between consecutive phases. A unipolar calibration has three measurement phases. A bipolar calibration has four, because one more measurement is needed. The mode is taken from the mode input in the cycle the request is accepted. During a phase, a one-hot phase output tells the offset/gain correction logic (outside this block) which measurement to take. A gap output marks the idle intervals. After the last phase the block waits one more output word and then resumes data-ready strobes with the valid flag set.

All durations are parameters: the filter window (8192 by default), the gap (512), the word period (64) and the phase counts (3 and 4).

Top module: `conv_cal_seq`

## Requirements
- R1: While `rst` is high, and in the cycle after it is sampled, `dvalid`, `drdy`, `cal_phase` and `cal_gap` are all 0. Reset then behaves like a restart request whose last sampled edge is the last reset edge.
- R2: While the block is in normal running, `drdy` is high for exactly one cycle every WORD_CYC cycles.
- R3: Let e be the last rising edge that samples `sync_req` (or `rst`) high. `dvalid` and `drdy` stay low until edge e + WINDOW_CYC + WORD_CYC. In the cycle after that edge `dvalid` is 1, and it stays 1 until the next restart or accepted calibration.
- R4: `dvalid` is 0 in the cycle after any edge that samples `sync_req` high, and it stays 0 while `sync_req` is held.
- R5: A `cal_req` sampled high during normal running with `bipolar`=0 starts a unipolar calibration of 3·WINDOW_CYC + 2·GAP_CYC cycles. The calibration runs measurement phases k = 0,1,2. In each phase `cal_phase` bit k alone is set for WINDOW_CYC cycles. Between phases, `cal_gap` is 1 for GAP_CYC cycles. Phase 0 starts in the cycle after the accepting edge.
- R6: With `bipolar`=1 at the accepting edge, the calibration has 4 measurement phases (bits 0..3) and 3 gaps, for 4·WINDOW_CYC + 3·GAP_CYC cycles.
- R7: After the calibration interval, all outputs stay 0 for WORD_CYC cycles. `dvalid` then rises together with the first `drdy` pulse.
- R8: `drdy` is never 1 while `dvalid` is 0.
- R9: `cal_req` has no effect during a calibration (phase, gap or post-calibration wait) or during settling.
- R10: Changing `bipolar` after a calibration has been accepted does not change that calibration's phase count or duration.
- R11: `sync_req` sampled high during a calibration aborts it and restarts settling as in R3. `sync_req` takes priority over a simultaneous `cal_req`.
- R12: At most one bit of `cal_phase` is set at any time, and never while `cal_gap` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high chip reset |
| sync_req | input | 1 | Synchronous restart request, sampled on the rising edge |
| cal_req | input | 1 | Calibration request, accepted only during normal running |
| bipolar | input | 1 | Input mode: 1 selects the bipolar calibration sequence |
| dvalid | output | 1 | Filter results are settled and trustworthy |
| drdy | output | 1 | One-cycle strobe per output word |
| cal_phase | output | BIP_PHASES | One-hot enable of the current measurement phase |
| cal_gap | output | 1 | High during the gaps between measurement phases |

## Verification
The embedded assertions check, on every cycle, the relations that hold locally in time. These are: the data-ready strobe never occurs without the valid flag and is never two cycles wide; the valid flag rises together with a strobe; a restart clears the valid flag and the phase outputs in the next cycle; the phase output stays one-hot and never overlaps a gap; the interval counter stays inside the current segment's length; and a gap is never followed by phase 0. The exact lengths of settling, of each phase and gap, and of the post-calibration wait, and the fact that requests and mode changes during a calibration are ignored, are shown only by the bench. It compares every output on every cycle of each scenario against arithmetic timelines, and it sweeps the calibration start over every offset within an output word in both modes.

// File: rtl/cs_pkg.sv
package cs_pkg;

    typedef enum logic [2:0] {
        SQ_SETTLE = 3'd0,
        SQ_RUN    = 3'd1,
        SQ_MEAS   = 3'd2,
        SQ_GAP    = 3'd3,
        SQ_POST   = 3'd4
    } sq_state_e;

    // run-state view handed to the output pacer
    typedef struct packed {
        logic run_now;
        logic run_next;
        logic beat;
    } sq_run_t;

    function automatic int unsigned cal_span(input int unsigned phases,
                                             input int unsigned win,
                                             input int unsigned gap);
        return phases * win + (phases - 1) * gap;
    endfunction

    function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/cs_interval_timer.sv
module cs_interval_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] cnt;

    assign last = (cnt == (limit - CW'(1)));

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (last) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R3
    cnt_in_range_chk: assert property (@(posedge clk) disable iff (rst)
        cnt < limit);

endmodule

// File: rtl/cs_phase_decode.sv
module cs_phase_decode #(
    parameter int NPH = 4,
    parameter int IW  = 2
) (
    input  logic          meas_en,
    input  logic [IW-1:0] idx,
    output logic [NPH-1:0] phase_oh
);
    for (genvar i = 0; i < NPH; i++) begin : g_bit
        assign phase_oh[i] = meas_en && (idx == IW'(i));
    end
endmodule

// File: rtl/cs_word_pacer.sv
module cs_word_pacer
    import cs_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  sq_run_t run,
    output logic    dvalid,
    output logic    drdy
);
    always_ff @(posedge clk) begin
        if (rst) begin
            dvalid <= 1'b0;
            drdy   <= 1'b0;
        end else begin
            dvalid <= run.run_next;
            drdy   <= run.run_next && (!run.run_now || run.beat);
        end
    end

    // R8
    drdy_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |-> dvalid);

    // R2
    drdy_single_chk: assert property (@(posedge clk) disable iff (rst)
        drdy |=> !drdy);

    // R7
    first_word_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dvalid) |-> drdy);

endmodule

// File: rtl/conv_cal_seq.sv
module conv_cal_seq
    import cs_pkg::*;
#(
    parameter int WINDOW_CYC = 8192,
    parameter int GAP_CYC    = 512,
    parameter int WORD_CYC   = 64,
    parameter int UNI_PHASES = 3,
    parameter int BIP_PHASES = 4
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  sync_req,
    input  logic                  cal_req,
    input  logic                  bipolar,
    output logic                  dvalid,
    output logic                  drdy,
    output logic [BIP_PHASES-1:0] cal_phase,
    output logic                  cal_gap
);
    localparam int SETTLE_CYC = WINDOW_CYC + WORD_CYC;
    localparam int LONGEST    = int'(max_u(SETTLE_CYC, cal_span(BIP_PHASES, WINDOW_CYC, GAP_CYC)));
    localparam int CW         = $clog2(LONGEST + 1);
    localparam int IW         = (BIP_PHASES > 1) ? $clog2(BIP_PHASES) : 1;

    sq_state_e     state, state_n;
    logic [IW-1:0] idx, idx_n;
    logic          mode_bip, mode_n;
    logic          restart;
    logic          last;
    logic [CW-1:0] limit;
    logic [IW-1:0] last_idx;
    sq_run_t       run;

    assign last_idx = mode_bip ? IW'(BIP_PHASES - 1) : IW'(UNI_PHASES - 1);

    // length of the segment currently being timed
    always_comb begin
        unique case (state)
            SQ_SETTLE: limit = CW'(SETTLE_CYC);
            SQ_MEAS:   limit = CW'(WINDOW_CYC);
            SQ_GAP:    limit = CW'(GAP_CYC);
            default:   limit = CW'(WORD_CYC);
        endcase
    end

    always_comb begin
        state_n = state;
        idx_n   = idx;
        mode_n  = mode_bip;
        restart = 1'b0;
        if (sync_req) begin
            state_n = SQ_SETTLE;
            idx_n   = '0;
            restart = 1'b1;
        end else begin
            unique case (state)
                SQ_SETTLE: if (last) state_n = SQ_RUN;
                SQ_RUN: if (cal_req) begin
                    state_n = SQ_MEAS;
                    idx_n   = '0;
                    mode_n  = bipolar;
                    restart = 1'b1;
                end
                SQ_MEAS: if (last) state_n = (idx == last_idx) ? SQ_POST : SQ_GAP;
                SQ_GAP: if (last) begin
                    state_n = SQ_MEAS;
                    idx_n   = idx + IW'(1);
                end
                SQ_POST: if (last) state_n = SQ_RUN;
                default: begin
                    state_n = SQ_SETTLE;
                    restart = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= SQ_SETTLE;
            idx      <= '0;
            mode_bip <= 1'b0;
        end else begin
            state    <= state_n;
            idx      <= idx_n;
            mode_bip <= mode_n;
        end
    end

    cs_interval_timer #(.CW(CW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .limit   (limit),
        .last    (last)
    );

    cs_phase_decode #(.NPH(BIP_PHASES), .IW(IW)) u_decode (
        .meas_en  (state == SQ_MEAS),
        .idx      (idx),
        .phase_oh (cal_phase)
    );

    assign cal_gap = (state == SQ_GAP);

    assign run.run_now  = (state == SQ_RUN);
    assign run.run_next = (state_n == SQ_RUN);
    assign run.beat     = last;

    cs_word_pacer u_pacer (
        .clk    (clk),
        .rst    (rst),
        .run    (run),
        .dvalid (dvalid),
        .drdy   (drdy)
    );

    // R4
    sync_drops_valid_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> !dvalid);

    // R11
    sync_clears_phase_chk: assert property (@(posedge clk) disable iff (rst)
        sync_req |=> (cal_phase == '0 && !cal_gap));

    // R12
    phase_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(cal_phase) && !(cal_gap && (cal_phase != '0)));

    // R9
    gap_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (cal_gap && cal_req && !sync_req) |=> !cal_phase[0]);

endmodule

// File: tb/conv_cal_seq_bench.sv
`timescale 1ns/1ps
module conv_cal_seq_bench;
    localparam int W  = 32;
    localparam int G  = 8;
    localparam int WD = 8;
    localparam int NU = 3;
    localparam int NB = 4;
    localparam int S  = W + WD;

    logic clk = 1'b0;
    logic rst, sync_req, cal_req, bipolar;
    logic dvalid, drdy, cal_gap;
    logic [NB-1:0] cal_phase;

    int edges = 0;
    int e0 = 0;
    int checks = 0;
    int errs = 0;

    always #2.5 clk = ~clk;
    always @(posedge clk) edges <= edges + 1;

    conv_cal_seq #(
        .WINDOW_CYC(W), .GAP_CYC(G), .WORD_CYC(WD),
        .UNI_PHASES(NU), .BIP_PHASES(NB)
    ) u_conv_cal_seq (
        .clk(clk), .rst(rst), .sync_req(sync_req), .cal_req(cal_req),
        .bipolar(bipolar), .dvalid(dvalid), .drdy(drdy),
        .cal_phase(cal_phase), .cal_gap(cal_gap)
    );

    // packed as {dvalid, drdy, cal_phase[3:0], cal_gap}
    function automatic logic [6:0] expect_at(input int kind, input int nph, input int t);
        logic dv, dr, gp;
        logic [3:0] ph;
        int c;
        dv = 0; dr = 0; gp = 0; ph = '0;
        if (kind == 0) begin
            dv = (t >= S);
            dr = dv && (((t - S) % WD) == 0);
        end else begin
            c = nph * W + (nph - 1) * G;
            if (t < c) begin
                if ((t % (W + G)) < W) ph = 4'(1 << (t / (W + G)));
                else gp = 1;
            end else if (t >= c + WD) begin
                dv = 1;
                dr = (((t - c - WD) % WD) == 0);
            end
        end
        return {dv, dr, ph, gp};
    endfunction

    task automatic chk(input string req, input logic [6:0] act, input logic [6:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%b expected=%b at t=%0d", req, act, exp, edges - e0);
        end
    endtask

    task automatic watch(input int kind, input int nph, input int n, input string req);
        for (int i = 0; i < n; i++) begin
            chk(req, {dvalid, drdy, cal_phase, cal_gap}, expect_at(kind, nph, edges - e0));
            @(negedge clk);
        end
    endtask

    task automatic start_cal(input logic mode);
        bipolar = mode;
        cal_req = 1'b1;
        e0 = edges + 1;
        @(negedge clk);
        cal_req = 1'b0;
    endtask

    initial begin
        rst = 1'b1; sync_req = 1'b0; cal_req = 1'b0; bipolar = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", {dvalid, drdy, cal_phase, cal_gap}, 7'b0);
        rst = 1'b0;
        e0 = edges;
        watch(0, 0, S + 3 * WD, "R2 R3 R8");

        // restart held for several cycles
        sync_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R4", {dvalid, drdy}, 2'b00);
        end
        sync_req = 1'b0;
        e0 = edges;
        watch(0, 0, S + 2 * WD, "R4 R3");

        // calibration start swept over every offset within a word, both modes
        for (int off = 0; off < WD; off++) begin
            for (int m = 0; m < 2; m++) begin
                repeat (off) @(negedge clk);
                start_cal(m[0]);
                if (m == 0) watch(1, NU, NU * W + (NU - 1) * G + 3 * WD, "R5 R7 R12");
                else        watch(1, NB, NB * W + (NB - 1) * G + 3 * WD, "R6 R7 R12");
            end
        end

        // requests and mode change during a bipolar calibration
        start_cal(1'b1);
        watch(1, NB, 50, "R10");
        cal_req = 1'b1; bipolar = 1'b0;
        watch(1, NB, 1, "R9 R10");
        cal_req = 1'b0;
        watch(1, NB, W + 10, "R9 R10");
        cal_req = 1'b1;
        watch(1, NB, 1, "R9");
        cal_req = 1'b0;
        watch(1, NB, NB * W + (NB - 1) * G + 3 * WD - (edges - e0), "R9 R10");

        // request during settling
        sync_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0;
        e0 = edges;
        watch(0, 0, 5, "R9");
        cal_req = 1'b1;
        watch(0, 0, 1, "R9");
        cal_req = 1'b0;
        watch(0, 0, S + 2 * WD - 6, "R9");

        // abort a calibration, restart beating a simultaneous request
        start_cal(1'b0);
        watch(1, NU, 60, "R11");
        sync_req = 1'b1; cal_req = 1'b1;
        @(negedge clk);
        sync_req = 1'b0; cal_req = 1'b0;
        e0 = edges;
        watch(0, 0, S + 2 * WD, "R11");

        // reset during normal running
        rst = 1'b1;
        @(negedge clk);
        chk("R1", {dvalid, drdy, cal_phase, cal_gap}, 7'b0);
        rst = 1'b0;
        e0 = edges;
        watch(0, 0, S + 2 * WD, "R1 R3");

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule